// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns one packed configuration word into the time structure of a CAN bit. A prescaler divides the system clock into time quanta. Every bit opens with a one-quantum sync segment, followed by a first timing segment and a second timing segment. The block raises a one-cycle strobe at the sample point and another at the end of each bit. At the sample point it presents the received bit value. That value is either the line level in the sampling quantum or a majority vote over three consecutive quanta.

Falling edges on the receive line (recessive 1 to dominant 0) move the bit grid. When the protocol layer asserts `hard_sync_en`, which it does while the bus is idle, an edge restarts the bit. Otherwise an edge resynchronizes the bit by stretching the first segment or trimming the second, limited by the jump width. Configuration is captured only while `cfg_hold` is high, which is the controller's reset mode. Bit stuffing, framing and CRC belong to the layer above.

Top module: `can_bit_timer`

## Requirements
- R1: The fields of `cfg_word` each hold their value minus one: bits 9:0 prescaler (BRP), bits 15:14 jump width (SJW), bits 19:16 first segment (T1), bits 22:20 second segment (T2). Bit 23 set selects triple sampling. One quantum lasts BRP clock cycles.
- R2: With no falling edge on the line, `bit_stb` pulses for a single cycle every (1+T1+T2)*BRP cycles.
- R3: `sample_stb` pulses (T1+1)*BRP cycles after the start of a bit. The two strobes are never high in the same cycle.
- R4: While `cfg_hold` is high, the configuration is loaded, both strobes stay 0 and `bit_val` is 1. A change of `cfg_word` while `cfg_hold` is low has no effect on the timing.
- R5: After `cfg_hold` falls, the first `sample_stb` is seen (T1+1)*BRP cycles later and the first `bit_stb` (1+T1+T2)*BRP cycles later.
- R6: With triple sampling off, `bit_val` takes the line level of the sampling quantum in the same cycle that `sample_stb` rises, and it holds at all other times.
- R7: With triple sampling on, `bit_val` is the majority of the line levels in the last three quanta ending at the sample point.
- R8: The line is registered once and then taken at the last clock of every quantum. A falling edge is a quantum taken as 1 followed by a quantum taken as 0. An edge in quantum q with 1 <= q <= T1 lengthens the first segment by min(q, SJW). An edge in quantum 0 causes no adjustment.
- R9: An edge in quantum q of the second segment (q > T1) shortens the bit by min(1+T1+T2-q, SJW) quanta. When that covers the full error, the edge quantum becomes the sync segment of the next bit, and `bit_stb` pulses at its end.
- R10: With `hard_sync_en` high, an edge in quantum q makes that quantum the sync segment of a new bit. The interrupted bit gives no strobe.
- R11: Only the first edge of a bit adjusts it. Later edges in the same bit are ignored.
- R12: During reset both strobes are 0 and `bit_val` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hold | input | 1 | Reset mode: load configuration, hold timing idle |
| cfg_word | input | 24 | Packed timing configuration |
| hard_sync_en | input | 1 | Bus idle: edges hard-synchronize |
| rx_in | input | 1 | Receive line, 1 = recessive |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| bit_stb | output | 1 | One-cycle pulse at the end of a bit |
| bit_val | output | 1 | Sampled bit value |

## Verification
A resynchronizing edge and the sample point can fall in the same quantum. This happens when the edge lands in the last quantum of the first segment, which is the quantum that would otherwise produce the sample. The bench drives the falling edge so that it is taken in exactly that quantum. It then expects the sample strobe to be pushed back by the jump width and the bit end to move with it, instead of a sample in the edge quantum. Edges in the sync quantum and at the last quantum of the second segment are also driven, and the strobe positions are judged against cycle counts computed from the segment arithmetic.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int CFG_W   = 24;
  localparam int BRP_W   = 10;
  localparam int SJW_W   = 2;
  localparam int T1_W    = 4;
  localparam int T2_W    = 3;
  localparam int BRP_LSB = 0;
  localparam int SJW_LSB = 14;
  localparam int T1_LSB  = 16;
  localparam int T2_LSB  = 20;
  localparam int TRI_BIT = 23;
  // quantum index must hold T1+T2+SJW (at most 28) plus arithmetic headroom
  localparam int QW      = 6;

  typedef struct packed {
    logic             triple;
    logic [T2_W-1:0]  t2_m1;
    logic [T1_W-1:0]  t1_m1;
    logic [SJW_W-1:0] sjw_m1;
    logic [BRP_W-1:0] brp_m1;
  } bt_cfg_t;

  function automatic bt_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    bt_cfg_t c;
    c.brp_m1 = w[BRP_LSB +: BRP_W];
    c.sjw_m1 = w[SJW_LSB +: SJW_W];
    c.t1_m1  = w[T1_LSB  +: T1_W];
    c.t2_m1  = w[T2_LSB  +: T2_W];
    c.triple = w[TRI_BIT];
    return c;
  endfunction
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [CW-1:0] div_m1,
  output logic          tq_tick
);
  logic [CW-1:0] cnt;

  assign tq_tick = !hold && (cnt == div_m1);

  always_ff @(posedge clk) begin
    if (rst || hold)  cnt <= '0;
    else if (tq_tick) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= div_m1);
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic tq_tick,
  input  logic triple,
  input  logic rx_in,
  output logic rx_fall,
  output logic vote
);
  localparam int HW = 2;  // earlier quanta kept besides the current one
  logic          rx_s;
  logic [HW-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      rx_s <= 1'b1;
      hist <= '1;
    end else begin
      rx_s <= rx_in;
      if (tq_tick) hist <= {hist[HW-2:0], rx_s};
    end
  end

  assign rx_fall = tq_tick && hist[0] && !rx_s;

  always_comb begin
    if (triple) vote = (hist[1] & hist[0]) | (hist[1] & rx_s) | (hist[0] & rx_s);
    else        vote = rx_s;
  end

  // R8
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    rx_fall |=> (hist[0] == 1'b0));
endmodule

// File: rtl/can_bt_segment.sv
module can_bt_segment #(
  parameter int QW  = 6,
  parameter int T1W = 4,
  parameter int T2W = 3,
  parameter int SW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           tq_tick,
  input  logic           rx_fall,
  input  logic           hs_en,
  input  logic [T1W-1:0] t1_m1,
  input  logic [T2W-1:0] t2_m1,
  input  logic [SW-1:0]  sjw_m1,
  output logic           smp_now,
  output logic           end_now
);
  logic [QW-1:0] q, ext, shr;
  logic          done;

  logic [QW-1:0] t1, t2, sjw, last, total, samp_idx, end_idx;
  logic [QW-1:0] lat_ph, ext_new, shr_new, last_m_shr;
  logic          hard, early, late, late_full, late_now, plain;

  always_comb begin
    t1         = QW'(t1_m1) + QW'(1);
    t2         = QW'(t2_m1) + QW'(1);
    sjw        = QW'(sjw_m1) + QW'(1);
    last       = t1 + t2;
    total      = last + QW'(1);
    samp_idx   = t1 + ext;
    end_idx    = last + ext - shr;
    lat_ph     = total - q;
    ext_new    = (q < sjw) ? q : sjw;
    shr_new    = (lat_ph < sjw) ? lat_ph : sjw;
    last_m_shr = last - shr_new;

    hard      = tq_tick && rx_fall && hs_en;
    early     = tq_tick && rx_fall && !hs_en && !done && (q != '0) && (q <= t1);
    late      = tq_tick && rx_fall && !hs_en && !done && (q > t1);
    late_full = late && (shr_new == lat_ph);
    late_now  = late && !late_full && (last_m_shr == q);
    plain     = tq_tick && !hard && !early && !late;

    smp_now   = plain && (q == samp_idx);
    end_now   = late_full || late_now || (plain && (q == end_idx));
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      q <= '0; ext <= '0; shr <= '0; done <= 1'b0;
    end else if (hard || late_full) begin
      q <= QW'(1); ext <= '0; shr <= '0; done <= 1'b0;
    end else if (late_now) begin
      q <= '0; ext <= '0; shr <= '0; done <= 1'b0;
    end else if (early) begin
      ext <= ext_new; done <= 1'b1; q <= q + QW'(1);
    end else if (late) begin
      shr <= shr_new; done <= 1'b1; q <= q + QW'(1);
    end else if (plain) begin
      if (q == end_idx) begin
        q <= '0; ext <= '0; shr <= '0; done <= 1'b0;
      end else begin
        q <= q + QW'(1);
      end
    end
  end

  // R8
  q_bound_chk: assert property (@(posedge clk) disable iff (rst)
    q <= last + sjw);

  // R11
  one_adjust_chk: assert property (@(posedge clk) disable iff (rst || hold)
    (done && !end_now && !hard && tq_tick) |=> done);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_hold,
  input  logic [can_bt_pkg::CFG_W-1:0] cfg_word,
  input  logic                       hard_sync_en,
  input  logic                       rx_in,
  output logic                       sample_stb,
  output logic                       bit_stb,
  output logic                       bit_val
);
  import can_bt_pkg::*;

  bt_cfg_t cfg_r;
  logic    tq_tick, rx_fall, vote, smp_now, end_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_r      <= '0;
      sample_stb <= 1'b0;
      bit_stb    <= 1'b0;
      bit_val    <= 1'b1;
    end else if (cfg_hold) begin
      cfg_r      <= unpack_cfg(cfg_word);
      sample_stb <= 1'b0;
      bit_stb    <= 1'b0;
      bit_val    <= 1'b1;
    end else begin
      sample_stb <= smp_now;
      bit_stb    <= end_now;
      if (smp_now) bit_val <= vote;
    end
  end

  can_bt_prescaler #(.CW(BRP_W)) u_presc (
    .clk(clk), .rst(rst), .hold(cfg_hold),
    .div_m1(cfg_r.brp_m1), .tq_tick(tq_tick)
  );

  can_bt_sampler u_samp (
    .clk(clk), .rst(rst), .hold(cfg_hold), .tq_tick(tq_tick),
    .triple(cfg_r.triple), .rx_in(rx_in),
    .rx_fall(rx_fall), .vote(vote)
  );

  can_bt_segment #(.QW(QW), .T1W(T1_W), .T2W(T2_W), .SW(SJW_W)) u_seg (
    .clk(clk), .rst(rst), .hold(cfg_hold), .tq_tick(tq_tick),
    .rx_fall(rx_fall), .hs_en(hard_sync_en),
    .t1_m1(cfg_r.t1_m1), .t2_m1(cfg_r.t2_m1), .sjw_m1(cfg_r.sjw_m1),
    .smp_now(smp_now), .end_now(end_now)
  );

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && bit_stb));

  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_hold |=> (!sample_stb && !bit_stb && bit_val));

  // R4
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_hold && !$past(cfg_hold)) |-> $stable(cfg_r));

  // R6
  val_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sample_stb && !$past(cfg_hold)) |-> $stable(bit_val));

  // R2
  bit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);
endmodule

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;
  logic        clk = 1'b0, rst = 1'b1, cfg_hold = 1'b1, hard_sync_en = 1'b0, rx_in = 1'b1;
  logic [23:0] cfg_word = '0;
  logic        sample_stb, bit_stb, bit_val;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  can_bit_timer u0 (
    .clk(clk), .rst(rst), .cfg_hold(cfg_hold), .cfg_word(cfg_word),
    .hard_sync_en(hard_sync_en), .rx_in(rx_in),
    .sample_stb(sample_stb), .bit_stb(bit_stb), .bit_val(bit_val)
  );

  function automatic logic [23:0] mk(int brp, int sjw, int t1, int t2, bit tr);
    logic [23:0] w = '0;
    w[9:0]   = 10'(brp - 1);
    w[15:14] = 2'(sjw - 1);
    w[19:16] = 4'(t1 - 1);
    w[22:20] = 3'(t2 - 1);
    w[23]    = tr;
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input logic [23:0] w);
    @(negedge clk);
    cfg_hold = 1'b1;
    cfg_word = w;
    repeat (3) @(negedge clk);
    cfg_hold = 1'b0;
  endtask

  // waits for a bit boundary, then drives quantum k of the next bit dominant when dom[k]
  task automatic run_bit(input logic [63:0] dom, input int brp,
                         output int sc, output int bc, output logic bv);
    int lim = 0;
    int cnt = 0;
    while (!bit_stb && lim < 5000) begin @(negedge clk); lim++; end
    sc = -1; bc = -1; bv = 1'b1;
    rx_in = ~dom[0];
    while (bc < 0 && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      if (sample_stb && sc < 0) begin sc = cnt; bv = bit_val; end
      if (bit_stb) bc = cnt;
      if ((cnt % brp) == 0 && (cnt / brp) < 64) rx_in = ~dom[cnt / brp];
    end
    rx_in = 1'b1;
  endtask

  task automatic first_bits(input int brp, input int t1, input int t2);
    int cnt = 0, sc = -1, b1 = -1, b2 = -1;
    int tot = 1 + t1 + t2;
    load(mk(brp, 1, t1, t2, 1'b0));
    while (b2 < 0 && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      if (sample_stb && sc < 0) sc = cnt;
      if (bit_stb) begin
        if (b1 < 0) b1 = cnt; else b2 = cnt;
      end
    end
    chk(sc == (t1 + 1) * brp, "R3/R5 first sample", sc, (t1 + 1) * brp);
    chk(b1 == tot * brp, "R1/R5 first bit end", b1, tot * brp);
    chk((b2 - b1) == tot * brp, "R2 bit period", b2 - b1, tot * brp);
  endtask

  task automatic resync_case(input string tag, input int sjw, input bit tr, input bit hs,
                             input logic [63:0] dom, input int esc, input int ebc, input logic ebv);
    int sc, bc;
    logic bv;
    load(mk(2, sjw, 6, 3, tr));
    hard_sync_en = hs;
    run_bit(dom, 2, sc, bc, bv);
    hard_sync_en = 1'b0;
    chk(sc == esc, {tag, " sample"}, sc, esc);
    chk(bc == ebc, {tag, " bit end"}, bc, ebc);
    chk(bv == ebv, {tag, " value"}, int'(bv), int'(ebv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 150000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int sc, bc;
    logic bv;
    logic quiet;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(!sample_stb && !bit_stb && bit_val, "R12 reset outputs", {sample_stb, bit_stb, bit_val}, 1);
    rst = 1'b0;
    // R4 hold keeps outputs quiet
    quiet = 1'b1;
    cfg_word = mk(1, 1, 1, 1, 1'b0);
    repeat (12) begin
      @(negedge clk);
      if (sample_stb || bit_stb || !bit_val) quiet = 1'b0;
    end
    chk(quiet, "R4 hold quiet", int'(quiet), 1);

    // R1 R2 R3 R5 sweep
    for (int b = 1; b <= 3; b++)
      for (int a = 1; a <= 16; a++)
        for (int c = 1; c <= 8; c++)
          first_bits(b, a, c);
    first_bits(64, 1, 1);

    // R4 config ignored when not in hold
    load(mk(2, 2, 6, 3, 1'b0));
    run_bit('0, 2, sc, bc, bv);
    cfg_word = mk(1, 1, 2, 2, 1'b0);
    run_bit('0, 2, sc, bc, bv);
    chk(bc == 20, "R4 live cfg change ignored (bit)", bc, 20);
    chk(sc == 14, "R4 live cfg change ignored (sample)", sc, 14);

    // R8 edge in sync quantum ignored
    resync_case("R8 sync edge", 2, 1'b0, 1'b0, ~64'd0 << 0, 14, 20, 1'b0);
    // R8 early-segment edges
    resync_case("R8 edge q1", 2, 1'b0, 1'b0, ~64'd0 << 1, 16, 22, 1'b0);
    resync_case("R8 edge q5", 2, 1'b0, 1'b0, ~64'd0 << 5, 18, 24, 1'b0);
    resync_case("R8 sjw1 q4", 1, 1'b0, 1'b0, ~64'd0 << 4, 16, 22, 1'b0);
    // R8 edge on the sampling quantum: sample deferred
    resync_case("R8 edge on sample quantum", 2, 1'b0, 1'b0, ~64'd0 << 6, 18, 24, 1'b0);
    // R9 second-segment edges
    resync_case("R9 full", 2, 1'b0, 1'b0, ~64'd0 << 8, 14, 18, 1'b1);
    resync_case("R9 partial", 2, 1'b0, 1'b0, ~64'd0 << 7, 14, 16, 1'b1);
    // R11 second edge ignored
    resync_case("R11 one adjust", 4, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFA, 16, 22, 1'b0);
    // R10 hard sync
    resync_case("R10 hard sync", 2, 1'b0, 1'b1, ~64'd0 << 3, 20, 26, 1'b0);
    // R6 single sampling uses the sample quantum only
    resync_case("R6 single", 1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFBF, 14, 18, 1'b1);
    // R7 triple sampling majority
    resync_case("R7 triple 2low", 1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFBF, 14, 18, 1'b0);
    resync_case("R7 triple 2high", 1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FF9F, 14, 18, 1'b1);
    resync_case("R7 triple all low", 1, 1'b1, 1'b0, ~64'd0, 14, 20, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule